// File: doc/BRIEF.md
# Burst Read Command Selector

This block picks the bus command that a bus master issues for a transfer. For reads it compares the transfer length, counted in 32-bit words, against a programmed cache line size. It chooses a plain read, a line read or a multiple-line read depending on how many whole lines the transfer spans. For writes it picks the invalidating write only when the transfer covers a whole, nonzero number of lines. In every other case it issues a plain write.

The block also holds two 8-bit configuration registers, the cache line size and the latency timer, with write strobes and a readback path. It flags whether bursting is allowed, which requires a nonzero latency timer. The command output follows the word count and direction inputs without a register stage. A register write changes the command from the next clock edge onward.

Top module: `burst_cmd_sel`

## Requirements
- R1: After reset both configuration registers read back 0 and `burstEn` is 0.
- R2: A write with `cfgWrEn`=1 and `cfgSel`=0 stores all 8 bits of `cfgWrData` as the cache line size, which reads back on `cfgRdData` with `cfgRdSel`=0 after the clock edge.
- R3: A write with `cfgWrEn`=1 and `cfgSel`=1 stores `cfgWrData` into the latency timer with bits 1:0 forced to 0, and readback with `cfgRdSel`=1 always shows bits 1:0 as 0.
- R4: `burstEn` is 1 exactly when the stored latency timer value is nonzero.
- R5: For a read (`isWrite`=0) with a nonzero line size L and word count W < L, `busCmd` is 0x6.
- R6: For a read with L nonzero and L <= W < 2L, `busCmd` is 0xE.
- R7: For a read with L nonzero and W >= 2L, `busCmd` is 0xC.
- R8: For a read with L = 0, `busCmd` is 0x6 for every word count.
- R9: For a write (`isWrite`=1), `busCmd` is 0xF when L is nonzero, W is nonzero and W is a whole multiple of L; otherwise it is 0x7.
- R10: `busCmd` is combinational in `wordCount` and `isWrite` and uses the register values held before the edge. A register write in the same cycle changes the command only after that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordCount | input | WC_W | Transfer length in 32-bit words |
| isWrite | input | 1 | 1 for a write transfer, 0 for a read |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgSel | input | 1 | Write target: 0 cache line size, 1 latency timer |
| cfgWrData | input | REG_W | Configuration write data |
| cfgRdSel | input | 1 | Readback select: 0 cache line size, 1 latency timer |
| cfgRdData | output | REG_W | Readback of the selected register |
| busCmd | output | 4 | Selected bus command code |
| burstEn | output | 1 | Bursting allowed (latency timer nonzero) |

## Verification
Two functions can fall in the same cycle: a register write and a command lookup that depends on the register being written. The bench drives a cache line size write and a read or write request in the same cycle. It requires the command sampled before the edge to follow the old line size and the command sampled after the edge to follow the new one. Random write strobes laid over random transfers exercise the same overlap many more times, and each result is compared against a bench model that is updated only at the edge.

// File: rtl/burst_cmd_pkg.sv
package burst_cmd_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_READ    = 4'h6,
    CMD_WRITE   = 4'h7,
    CMD_RD_MULT = 4'hC,
    CMD_RD_LINE = 4'hE,
    CMD_WR_INV  = 4'hF
  } busCmd_e;

  typedef struct packed {
    logic wrCline;
    logic wrLat;
  } cfgStrb_t;
endpackage

// File: rtl/burst_cmd_ctrl.sv
module burst_cmd_ctrl
  import burst_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWrEn,
  input  logic     cfgSel,
  output cfgStrb_t strb
);
  always_comb begin
    strb.wrCline = cfgWrEn && !cfgSel;
    strb.wrLat   = cfgWrEn &&  cfgSel;
  end

  // R10: at most one register is updated per cycle
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCline, strb.wrLat}));

  // R2: no register update without the write enable
  a_r2_strobe_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCline || strb.wrLat) |-> cfgWrEn);
endmodule

// File: rtl/burst_cmd_dp.sv
module burst_cmd_dp
  import burst_cmd_pkg::*;
#(
  parameter int WC_W  = 12,
  parameter int REG_W = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrb_t         strb,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             cfgRdSel,
  input  logic [WC_W-1:0]  wordCount,
  input  logic             isWrite,
  output logic [REG_W-1:0] cfgRdData,
  output busCmd_e          busCmd,
  output logic             burstEn
);
  localparam int LAT_RO = 2;
  localparam int CMP_W  = ((WC_W > REG_W + 1) ? WC_W : REG_W + 1) + 1;

  logic [REG_W-1:0] clineQ, latQ;
  logic [CMP_W-1:0] wcExt, oneLine, twoLine, remW;
  logic             wholeLines;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clineQ <= '0;
      latQ   <= '0;
    end else begin
      if (strb.wrCline) clineQ <= cfgWrData;
      if (strb.wrLat)   latQ   <= {cfgWrData[REG_W-1:LAT_RO], LAT_RO'(0)};
    end
  end

  always_comb begin
    wcExt      = CMP_W'(wordCount);
    oneLine    = CMP_W'(clineQ);
    twoLine    = oneLine << 1;
    remW       = (clineQ == '0) ? '0 : (wcExt % oneLine);
    wholeLines = (clineQ != '0) && (wordCount != '0) && (remW == '0);
    if (isWrite)
      busCmd = wholeLines ? CMD_WR_INV : CMD_WRITE;
    else if (clineQ == '0 || wcExt < oneLine)
      busCmd = CMD_READ;
    else if (wcExt < twoLine)
      busCmd = CMD_RD_LINE;
    else
      busCmd = CMD_RD_MULT;
  end

  assign burstEn   = (latQ != '0);
  assign cfgRdData = cfgRdSel ? latQ : clineQ;

  // R2: a line size write lands intact on the next cycle
  a_r2_cline_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCline |=> (clineQ == $past(cfgWrData)));

  // R3: low latency bits never read back as set
  a_r3_lat_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdSel |-> (cfgRdData[LAT_RO-1:0] == '0));

  // R4: bursting can only switch on after a latency write
  a_r4_burst_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(burstEn) |-> $past(strb.wrLat));

  // R8: zero line size always yields a plain read
  a_r8_zero_line_read: assert property (@(posedge clk) disable iff (!rstN)
    (!isWrite && clineQ == '0) |-> (busCmd == CMD_READ));

  // R9: invalidating write only for a nonzero write of nonzero lines
  a_r9_wrinv_cond: assert property (@(posedge clk) disable iff (!rstN)
    (busCmd == CMD_WR_INV) |-> (isWrite && clineQ != '0 && wordCount != '0));

  // R9: direction and command family agree
  a_r9_write_family: assert property (@(posedge clk) disable iff (!rstN)
    isWrite |-> (busCmd == CMD_WRITE || busCmd == CMD_WR_INV));
endmodule

// File: rtl/burst_cmd_sel.sv
module burst_cmd_sel
  import burst_cmd_pkg::*;
#(
  parameter int WC_W  = 12,
  parameter int REG_W = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [WC_W-1:0]  wordCount,
  input  logic             isWrite,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             cfgRdSel,
  output logic [REG_W-1:0] cfgRdData,
  output logic [CMD_W-1:0] busCmd,
  output logic             burstEn
);
  cfgStrb_t strb;
  busCmd_e  cmdSel;

  burst_cmd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgSel  (cfgSel),
    .strb    (strb)
  );

  burst_cmd_dp #(.WC_W(WC_W), .REG_W(REG_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgWrData (cfgWrData),
    .cfgRdSel  (cfgRdSel),
    .wordCount (wordCount),
    .isWrite   (isWrite),
    .cfgRdData (cfgRdData),
    .busCmd    (cmdSel),
    .burstEn   (burstEn)
  );

  assign busCmd = cmdSel;
endmodule

// File: tb/burst_cmd_sel_bench.sv
module burst_cmd_sel_bench;
  localparam int WC_W  = 12;
  localparam int REG_W = 8;

  logic             clk = 0;
  logic             rstN = 0;
  logic [WC_W-1:0]  wordCount = '0;
  logic             isWrite = 0;
  logic             cfgWrEn = 0;
  logic             cfgSel = 0;
  logic [REG_W-1:0] cfgWrData = '0;
  logic             cfgRdSel = 0;
  logic [REG_W-1:0] cfgRdData;
  logic [3:0]       busCmd;
  logic             burstEn;

  int checks = 0;
  int errors = 0;
  int mCline = 0;
  int mLat = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_cmd_sel #(.WC_W(WC_W), .REG_W(REG_W)) u_burst_cmd_sel (
    .clk(clk), .rstN(rstN), .wordCount(wordCount), .isWrite(isWrite),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .cfgRdSel(cfgRdSel), .cfgRdData(cfgRdData), .busCmd(busCmd),
    .burstEn(burstEn)
  );

  function automatic int expCmd(int wc, bit wr, int cl);
    if (wr) return (cl != 0 && wc != 0 && (wc % cl) == 0) ? 32'hF : 32'h7;
    if (cl == 0 || wc < cl) return 32'h6;
    if (wc < 2 * cl) return 32'hE;
    return 32'hC;
  endfunction

  function automatic string cmdReq(int wc, bit wr, int cl);
    if (wr) return "R9";
    if (cl == 0) return "R8";
    if (wc < cl) return "R5";
    if (wc < 2 * cl) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic checkCmd(string tag);
    check(tag, int'(busCmd), expCmd(int'(wordCount), isWrite, mCline));
  endtask

  task automatic applyModel();
    if (cfgWrEn) begin
      if (cfgSel) mLat = int'(cfgWrData) & 32'hFC;
      else        mCline = int'(cfgWrData);
    end
  endtask

  task automatic setCfg(bit sel, int data);
    @(negedge clk);
    cfgWrEn = 1; cfgSel = sel; cfgWrData = REG_W'(data);
    @(posedge clk); #1;
    applyModel();
    cfgWrEn = 0;
  endtask

  task automatic req(int wc, bit wr);
    @(negedge clk);
    wordCount = WC_W'(wc); isWrite = wr;
    #1 checkCmd(cmdReq(wc, wr, mCline));
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: reset state
    cfgRdSel = 0; #1 check("R1", int'(cfgRdData), 0);
    cfgRdSel = 1; #1 check("R1", int'(cfgRdData), 0);
    check("R1", int'(burstEn), 0);

    // R8: zero line size reads
    req(5, 0); req(0, 0); req(4095, 0);
    req(8, 1);

    // R2 / R5..R7 / R9 with a line of 4 words
    setCfg(0, 4);
    cfgRdSel = 0; #1 check("R2", int'(cfgRdData), 4);
    req(3, 0); req(4, 0); req(7, 0); req(8, 0); req(200, 0);
    req(8, 1); req(4, 1); req(6, 1); req(0, 1);
    setCfg(0, 8'hFF);
    cfgRdSel = 0; #1 check("R2", int'(cfgRdData), 255);
    req(254, 0); req(255, 0); req(509, 0); req(510, 0); req(765, 1);

    // R3 / R4: latency low bits and burst flag
    setCfg(1, 3);
    cfgRdSel = 1; #1 check("R3", int'(cfgRdData), 0);
    check("R4", int'(burstEn), 0);
    setCfg(1, 8'h85);
    #1 check("R3", int'(cfgRdData), 8'h84);
    check("R4", int'(burstEn), 1);
    setCfg(1, 0);
    #1 check("R4", int'(burstEn), 0);

    // R10: line size write in the same cycle as a lookup
    setCfg(0, 4);
    @(negedge clk);
    wordCount = 4; isWrite = 0;
    cfgWrEn = 1; cfgSel = 0; cfgWrData = 8;
    #1 check("R10", int'(busCmd), 32'hE);
    @(posedge clk); #1;
    applyModel(); cfgWrEn = 0;
    check("R10", int'(busCmd), 32'h6);

    // random overlap of writes and lookups
    for (int i = 0; i < 400; i++) begin
      int cl;
      @(negedge clk);
      cl = mCline;
      wordCount = WC_W'(($urandom % 4 == 0) ? $urandom : $urandom % (3 * cl + 4));
      isWrite  = $urandom % 2;
      cfgRdSel = $urandom % 2;
      cfgWrEn  = ($urandom % 4 == 0);
      cfgSel   = $urandom % 2;
      cfgWrData = REG_W'(($urandom % 3 == 0) ? 0 : $urandom % 24);
      #1 checkCmd(cfgWrEn ? "R10" : cmdReq(int'(wordCount), isWrite, mCline));
      @(posedge clk); #1;
      applyModel();
      cfgWrEn = 0;
      check(cfgRdSel ? "R3" : "R2", int'(cfgRdData), cfgRdSel ? mLat : mCline);
      check("R4", int'(burstEn), (mLat != 0) ? 1 : 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule